// File: doc/BRIEF.md
# Multiplexed External Bus Interface

This block sits between an internal 16-bit CPU bus and two 8-bit pin ports that share address and data in time. Each bus cycle lasts two clocks. In the first clock the E output is low and the ports show the address. In the second clock E is high and the ports show write data, or the block samples read data when that clock ends. Four control outputs go with the ports:
- E
- R/W (1 = read, 0 = write)
- an active-high low-byte strobe
- a no-access flag

The block has two bus widths:
- **Wide mode** uses both ports as a 16-bit data path.
- **Narrow mode** carries external data on port A only. A 16-bit external access becomes two byte cycles: the high byte first at the even address, then the low byte at address+1.

A separate external cycle type always uses the full 16-bit path, in either mode. It serves the port-control registers that are mapped external.

An internal-visibility input decides which internal, debug and idle cycles appear on the pins. Cycles that do not appear leave the pins at their previous values.

The CPU holds one request on its inputs. A request is taken at a rising edge while `cpu_ready` is high. `cpu_ready` is high only during the final data phase of the current access. Read data shows on `cpu_rdata` from the clock that follows the final data phase.

Top module: `mux_ext_bus`

## Requirements
- R1: While reset is applied, the outputs have these values: `cpu_ready`=1, both ports 0, `e_out`=0, `rw_out`=1, `lo_strb`=0, `no_acc`=1, `bus_drive`=1, `cpu_rdata`=0.
- R2: A bus cycle has two clocks.
  - The request is taken at the rising edge where `cpu_ready` is high. The address phase follows (E low, `cpu_ready` low), then the data phase (E high for shown cycles).
  - In the address phase of a shown cycle, port A = address[15:8] and port B = address[7:0].
  - `cpu_type` codes: 0 idle, 1 internal, 2 external, 3 external full-path register, 4 debug. Codes 5 to 7 are reserved.
- R3: In a wide external write, R/W is 0. In the data phase, port A = wdata[15:8] and port B = wdata[7:0].
- R4: In an external read, R/W is 1 and `bus_drive` is 0 during the data phase. In wide mode, `cpu_rdata` = {port A in, port B in}, sampled as the data phase ends and shown from the next clock.
- R5: A narrow-mode 16-bit external write uses two cycles.
  - The cycles go to the address and then to address+1.
  - Port A carries the high byte and then the low byte. Port B carries the piece address[7:0] in both phases.
  - `cpu_ready` stays low through the first data phase.
- R6: In a narrow-mode 16-bit external read, port A in is stored to `cpu_rdata[15:8]` in the first cycle and to `cpu_rdata[7:0]` in the second.
- R7: A narrow-mode byte access takes one cycle, with its byte on port A.
  - An even address uses byte lane [15:8] and an odd address uses lane [7:0], for both the write data and the read data.
  - The other read byte keeps its value.
- R8: In narrow mode, a type-3 access takes a single cycle that carries 16 data bits across both ports.
- R9: With visibility off, an internal cycle behaves as follows:
  - E stays low and R/W is 1.
  - The address, data and strobe values stay as they were.
  - `no_acc` is 0.
- R10: With visibility on, an internal write has a 16-bit cycle: E pulses, the address is shown, the write data is on both ports, and R/W is 0. This holds in narrow mode too.
- R11: With visibility on, a debug cycle behaves as follows:
  - R/W is 1.
  - The address and the strobe are updated.
  - The data-phase port values stay as they were.
- R12: An idle cycle sets `no_acc` to 1 and R/W to 1, and the address, data and strobe stay as they were. E pulses if visibility is on and stays low if it is off.
- R13: The value of `lo_strb` depends on the access.
  - It is 1 for 16-bit accesses and for byte accesses to odd addresses, and 0 for byte accesses to even addresses.
  - In a narrow split access, it is 0 for the first piece and 1 for the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| narrow_mode | input | 1 | 1 = 8-bit external data path |
| int_vis | input | 1 | 1 = internal cycles shown on the pins |
| cpu_type | input | 3 | Cycle type of the request |
| cpu_addr | input | 16 | Request address |
| cpu_wdata | input | 16 | Write data (internal data word for internal cycles) |
| cpu_wr | input | 1 | 1 = write |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpu_ready | output | 1 | High in the final data phase; the request is taken at this edge |
| cpu_rdata | output | 16 | Read data |
| porta_in | input | 8 | Port A pin value for reads |
| portb_in | input | 8 | Port B pin value for reads |
| porta_out | output | 8 | Port A drive value |
| portb_out | output | 8 | Port B drive value |
| bus_drive | output | 1 | 0 while an external read owns the ports |
| e_out | output | 1 | E clock output |
| rw_out | output | 1 | Read/write output, 1 = read |
| lo_strb | output | 1 | Low-byte strobe, active high |
| no_acc | output | 1 | 1 = the CPU made no access this cycle |

## Verification
The bench builds the block with its default port width of 8 bits. With that width the address is 16 bits, and each pin bit maps to the address or data bit given in the requirements. Port A bit 7 carries A15, D15 and D7, and port B bit 0 carries A0. With this width the bench can also check the even-to-odd step of a narrow split and the byte-lane choice made from address bit 0. The bench changes the mode and visibility inputs only between accesses. In that way, wide, narrow, hidden and shown cycles all follow one another on the same held pin state.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE = 3'd0,
    CYC_INT  = 3'd1,
    CYC_EXT  = 3'd2,
    CYC_XREG = 3'd3,
    CYC_DBG  = 3'd4
  } cyc_e;

  // external cycle that uses only port A for data
  function automatic logic mxb_narrow_path(cyc_e t, logic narrow);
    return narrow && (t == CYC_EXT);
  endfunction

  // 16-bit access that takes two byte cycles
  function automatic logic mxb_is_split(cyc_e t, logic word, logic narrow);
    return mxb_narrow_path(t, narrow) && word;
  endfunction

endpackage

// File: rtl/mxb_seq.sv
module mxb_seq
  import mxb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          narrow,
  input  cyc_e          cpu_type,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_wr,
  input  logic          cpu_word,
  output logic          cpu_ready,
  output logic          phase_d,
  output logic          pc,
  output logic          sec_q,
  output cyc_e          sel_type,
  output logic [AW-1:0] sel_addr,
  output logic [DW-1:0] sel_wdata,
  output logic          sel_wr,
  output logic          sel_word,
  output cyc_e          rq_type,
  output logic          rq_addr0,
  output logic          rq_wr,
  output logic          rq_word
);

  logic          ph_n, sec_n;
  cyc_e          rq_type_n;
  logic [AW-1:0] rq_addr, rq_addr_n;
  logic [DW-1:0] rq_wdata, rq_wdata_n;
  logic          rq_wr_n, rq_word_n;

  always_comb begin
    cpu_ready  = phase_d && !(mxb_is_split(rq_type, rq_word, narrow) && !sec_q);
    sel_type   = cpu_ready ? cpu_type  : rq_type;
    sel_addr   = cpu_ready ? cpu_addr  : rq_addr;
    sel_wdata  = cpu_ready ? cpu_wdata : rq_wdata;
    sel_wr     = cpu_ready ? cpu_wr    : rq_wr;
    sel_word   = cpu_ready ? cpu_word  : rq_word;
    ph_n       = !phase_d;
    sec_n      = phase_d ? !cpu_ready : sec_q;
    pc         = sec_n;
    rq_type_n  = sel_type;
    rq_addr_n  = sel_addr;
    rq_wdata_n = sel_wdata;
    rq_wr_n    = sel_wr;
    rq_word_n  = sel_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_d  <= 1'b1;
      sec_q    <= 1'b0;
      rq_type  <= CYC_IDLE;
      rq_addr  <= '0;
      rq_wdata <= '0;
      rq_wr    <= 1'b0;
      rq_word  <= 1'b0;
    end else begin
      phase_d  <= ph_n;
      sec_q    <= sec_n;
      rq_type  <= rq_type_n;
      rq_addr  <= rq_addr_n;
      rq_wdata <= rq_wdata_n;
      rq_wr    <= rq_wr_n;
      rq_word  <= rq_word_n;
    end
  end

  assign rq_addr0 = rq_addr[0];

  // a data phase without ready leads into the second piece of a split
  p_split_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_d && !cpu_ready) |=> (sec_q && !phase_d));

endmodule

// File: rtl/mxb_drive.sv
module mxb_drive
  import mxb_pkg::*;
#(
  parameter int PW = 8,
  parameter int AW = 2 * PW,
  parameter int DW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          narrow,
  input  logic          ivis,
  input  logic          phase_d,
  input  logic          pc,
  input  cyc_e          sel_type,
  input  logic [AW-1:0] sel_addr,
  input  logic [DW-1:0] sel_wdata,
  input  logic          sel_wr,
  input  logic          sel_word,
  output logic [AW-1:0] adr_q,
  output logic [DW-1:0] dat_q,
  output logic          e_q,
  output logic          rw_q,
  output logic          strb_q,
  output logic          noacc_q,
  output logic          drv_q
);

  logic [AW-1:0] adr_n, piece_addr;
  logic [DW-1:0] dat_n;
  logic          e_n, rw_n, strb_n, noacc_n, drv_n, show_q, show_n;
  logic          ext_t, vis_t, data_t, npath, byte_sel;
  logic [PW-1:0] byte_val;

  always_comb begin
    ext_t      = (sel_type == CYC_EXT) || (sel_type == CYC_XREG);
    npath      = mxb_narrow_path(sel_type, narrow);
    vis_t      = ext_t || (ivis && ((sel_type == CYC_INT) || (sel_type == CYC_DBG)));
    data_t     = ext_t || (ivis && (sel_type == CYC_INT));
    piece_addr = sel_addr + {{(AW-1){1'b0}}, pc};
    byte_sel   = sel_word ? pc : sel_addr[0];
    byte_val   = byte_sel ? sel_wdata[PW-1:0] : sel_wdata[DW-1:PW];
    adr_n   = adr_q;
    dat_n   = dat_q;
    e_n     = e_q;
    rw_n    = rw_q;
    strb_n  = strb_q;
    noacc_n = noacc_q;
    drv_n   = drv_q;
    show_n  = show_q;
    if (phase_d) begin
      // entering the address phase
      e_n     = 1'b0;
      drv_n   = 1'b1;
      noacc_n = (sel_type == CYC_IDLE);
      rw_n    = data_t ? !sel_wr : 1'b1;
      show_n  = ext_t || ivis;
      if (vis_t) begin
        adr_n  = piece_addr;
        strb_n = npath ? piece_addr[0] : (sel_word | sel_addr[0]);
      end
    end else begin
      // entering the data phase
      e_n   = show_q;
      drv_n = !(ext_t && !sel_wr);
      if (npath) begin
        dat_n = {(sel_wr ? byte_val : dat_q[DW-1:PW]), piece_addr[PW-1:0]};
      end else if (data_t && sel_wr) begin
        dat_n = sel_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q   <= '0;
      dat_q   <= '0;
      e_q     <= 1'b0;
      rw_q    <= 1'b1;
      strb_q  <= 1'b0;
      noacc_q <= 1'b1;
      drv_q   <= 1'b1;
      show_q  <= 1'b0;
    end else begin
      adr_q   <= adr_n;
      dat_q   <= dat_n;
      e_q     <= e_n;
      rw_q    <= rw_n;
      strb_q  <= strb_n;
      noacc_q <= noacc_n;
      drv_q   <= drv_n;
      show_q  <= show_n;
    end
  end

  p_e_data_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    e_q |-> phase_d);

  p_hidden_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_d && !ivis && (sel_type == CYC_INT)) |=> ($stable(adr_q) && $stable(strb_q) && rw_q));

  p_dbg_rw_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_d && ivis && (sel_type == CYC_DBG)) |=> rw_q);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_d && (sel_type == CYC_IDLE)) |=> (noacc_q && rw_q && $stable(adr_q)));

endmodule

// File: rtl/mxb_rdcap.sv
module mxb_rdcap
  import mxb_pkg::*;
#(
  parameter int PW = 8,
  parameter int DW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          narrow,
  input  logic          phase_d,
  input  logic          sec_q,
  input  cyc_e          rq_type,
  input  logic          rq_addr0,
  input  logic          rq_wr,
  input  logic          rq_word,
  input  logic [PW-1:0] pa_in,
  input  logic [PW-1:0] pb_in,
  output logic [DW-1:0] rdata_q
);

  logic [DW-1:0] rdata_n;
  logic          take, lane;

  always_comb begin
    take    = phase_d && !rq_wr && ((rq_type == CYC_EXT) || (rq_type == CYC_XREG));
    lane    = rq_word ? sec_q : rq_addr0;
    rdata_n = rdata_q;
    if (take) begin
      if (mxb_narrow_path(rq_type, narrow)) begin
        if (lane) rdata_n[PW-1:0]  = pa_in;
        else      rdata_n[DW-1:PW] = pa_in;
      end else begin
        rdata_n = {pa_in, pb_in};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  // narrow even byte read leaves the low byte alone
  p_narrow_lane_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_d && narrow && (rq_type == CYC_EXT) && !rq_wr && !rq_word && !rq_addr0)
      |=> $stable(rdata_q[PW-1:0]));

endmodule

// File: rtl/mux_ext_bus.sv
module mux_ext_bus
  import mxb_pkg::*;
#(
  parameter int PW = 8,
  localparam int AW = 2 * PW,
  localparam int DW = 2 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          narrow_mode,
  input  logic          int_vis,
  input  logic [2:0]    cpu_type,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_wr,
  input  logic          cpu_word,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  input  logic [PW-1:0] porta_in,
  input  logic [PW-1:0] portb_in,
  output logic [PW-1:0] porta_out,
  output logic [PW-1:0] portb_out,
  output logic          bus_drive,
  output logic          e_out,
  output logic          rw_out,
  output logic          lo_strb,
  output logic          no_acc
);

  logic [1:0]    rst_pipe;
  logic          rst_s;
  logic          phase_d, pc, sec_q, sel_wr, sel_word, rq_addr0, rq_wr, rq_word;
  cyc_e          sel_type, rq_type;
  logic [AW-1:0] sel_addr, adr_q;
  logic [DW-1:0] sel_wdata, dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  mxb_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_s), .narrow(narrow_mode),
    .cpu_type(cyc_e'(cpu_type)), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_word(cpu_word), .cpu_ready(cpu_ready),
    .phase_d(phase_d), .pc(pc), .sec_q(sec_q),
    .sel_type(sel_type), .sel_addr(sel_addr), .sel_wdata(sel_wdata),
    .sel_wr(sel_wr), .sel_word(sel_word),
    .rq_type(rq_type), .rq_addr0(rq_addr0), .rq_wr(rq_wr), .rq_word(rq_word)
  );

  mxb_drive #(.PW(PW), .AW(AW), .DW(DW)) drive_i (
    .clk(clk), .rst_n(rst_s), .narrow(narrow_mode), .ivis(int_vis),
    .phase_d(phase_d), .pc(pc), .sel_type(sel_type), .sel_addr(sel_addr),
    .sel_wdata(sel_wdata), .sel_wr(sel_wr), .sel_word(sel_word),
    .adr_q(adr_q), .dat_q(dat_q), .e_q(e_out), .rw_q(rw_out),
    .strb_q(lo_strb), .noacc_q(no_acc), .drv_q(bus_drive)
  );

  mxb_rdcap #(.PW(PW), .DW(DW)) rdcap_i (
    .clk(clk), .rst_n(rst_s), .narrow(narrow_mode), .phase_d(phase_d),
    .sec_q(sec_q), .rq_type(rq_type), .rq_addr0(rq_addr0), .rq_wr(rq_wr),
    .rq_word(rq_word), .pa_in(porta_in), .pb_in(portb_in), .rdata_q(cpu_rdata)
  );

  // ports: address in the address phase, data register in the data phase
  assign porta_out = phase_d ? dat_q[DW-1:PW] : adr_q[AW-1:PW];
  assign portb_out = phase_d ? dat_q[PW-1:0]  : adr_q[PW-1:0];

endmodule

// File: tb/mux_ext_bus_tb_top.sv
module mux_ext_bus_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        narrow_mode, int_vis, cpu_wr, cpu_word;
  logic [2:0]  cpu_type;
  logic [15:0] cpu_addr, cpu_wdata;
  logic [7:0]  porta_in, portb_in;
  logic        cpu_ready, bus_drive, e_out, rw_out, lo_strb, no_acc;
  logic [15:0] cpu_rdata;
  logic [7:0]  porta_out, portb_out;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  mux_ext_bus dut_i (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode), .int_vis(int_vis),
    .cpu_type(cpu_type), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_word(cpu_word), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .porta_in(porta_in), .portb_in(portb_in),
    .porta_out(porta_out), .portb_out(portb_out), .bus_drive(bus_drive),
    .e_out(e_out), .rw_out(rw_out), .lo_strb(lo_strb), .no_acc(no_acc)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // pins packed as {pa, pb, e, rw, strb, noacc, ready}
  task automatic pins(string rq, logic [7:0] pa, logic [7:0] pb,
                      logic e, logic rw, logic st, logic na, logic rd);
    chk(rq, {11'd0, porta_out, portb_out, e_out, rw_out, lo_strb, no_acc, cpu_ready},
            {11'd0, pa, pb, e, rw, st, na, rd});
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // called at a falling edge; waits for ready, then presents a request
  task automatic go(logic [2:0] t, logic [15:0] a, logic [15:0] d, logic w, logic wd);
    while (!cpu_ready) @(negedge clk);
    cpu_type = t; cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_word = wd;
  endtask

  task automatic to_idle();
    cpu_type = 3'd0; cpu_wr = 1'b0; cpu_word = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset pins", {porta_out, portb_out, e_out, rw_out, lo_strb, no_acc, cpu_ready, bus_drive},
                         {16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1});
    chk("R1 reset rdata", {16'd0, cpu_rdata}, 32'd0);
  endtask

  task automatic t_wide_write();
    narrow_mode = 1'b0; int_vis = 1'b0;
    go(3'd2, 16'h1234, 16'hABCD, 1'b1, 1'b1);
    @(negedge clk); pins("R2 R13 wide write addr phase", 8'h12, 8'h34, 0, 0, 1, 0, 0);
    @(negedge clk); pins("R3 wide write data phase", 8'hAB, 8'hCD, 1, 0, 1, 0, 1);
    to_idle();
  endtask

  task automatic t_wide_read();
    go(3'd2, 16'h2000, 16'h0000, 1'b0, 1'b1);
    porta_in = 8'h5A; portb_in = 8'hC3;
    @(negedge clk); pins("R2 wide read addr phase", 8'h20, 8'h00, 0, 1, 1, 0, 0);
    @(negedge clk); chk("R4 read releases bus", {31'd0, bus_drive}, 32'd0);
    chk("R4 read e/rw", {30'd0, e_out, rw_out}, 32'd3);
    to_idle();
    @(negedge clk); chk("R4 wide read data", {16'd0, cpu_rdata}, 32'h5AC3);
    // strobe for byte accesses
    go(3'd2, 16'h2001, 16'h0000, 1'b0, 1'b0);
    @(negedge clk); chk("R13 odd byte strobe", {31'd0, lo_strb}, 32'd1);
    @(negedge clk); to_idle();
    go(3'd2, 16'h2002, 16'h0000, 1'b0, 1'b0);
    @(negedge clk); chk("R13 even byte strobe", {31'd0, lo_strb}, 32'd0);
    @(negedge clk); to_idle();
  endtask

  task automatic t_narrow_split_write();
    narrow_mode = 1'b1;
    go(3'd2, 16'h4410, 16'h1357, 1'b1, 1'b1);
    @(negedge clk); pins("R5 R13 split piece0 addr", 8'h44, 8'h10, 0, 0, 0, 0, 0);
    @(negedge clk); pins("R5 split piece0 data no ready", 8'h13, 8'h10, 1, 0, 0, 0, 0);
    @(negedge clk); pins("R5 R13 split piece1 addr", 8'h44, 8'h11, 0, 0, 1, 0, 0);
    @(negedge clk); pins("R5 split piece1 data", 8'h57, 8'h11, 1, 0, 1, 0, 1);
    to_idle();
  endtask

  task automatic t_narrow_split_read();
    go(3'd2, 16'h4420, 16'h0000, 1'b0, 1'b1);
    porta_in = 8'h9A;
    @(negedge clk); @(negedge clk);
    @(negedge clk); porta_in = 8'hBC;
    chk("R6 split read piece1 addr", {16'd0, porta_out, portb_out}, 32'h4421);
    @(negedge clk); to_idle();
    @(negedge clk); chk("R6 split read data", {16'd0, cpu_rdata}, 32'h9ABC);
  endtask

  task automatic t_narrow_byte();
    go(3'd2, 16'h4431, 16'h00EE, 1'b1, 1'b0);
    @(negedge clk); chk("R7 R13 byte odd strobe", {31'd0, lo_strb}, 32'd1);
    @(negedge clk); pins("R7 narrow byte write one cycle", 8'hEE, 8'h31, 1, 0, 1, 0, 1);
    to_idle();
    go(3'd2, 16'h4430, 16'h0000, 1'b0, 1'b0);
    porta_in = 8'h77;
    @(negedge clk); @(negedge clk);
    chk("R7 byte read single cycle ready", {31'd0, cpu_ready}, 32'd1);
    to_idle();
    @(negedge clk); chk("R7 even byte read lane", {16'd0, cpu_rdata}, 32'h77BC);
  endtask

  task automatic t_narrow_reg();
    go(3'd3, 16'h0002, 16'h2468, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    pins("R8 full-path reg write", 8'h24, 8'h68, 1, 0, 1, 0, 1);
    to_idle();
  endtask

  task automatic t_hidden();
    narrow_mode = 1'b0; int_vis = 1'b0;
    go(3'd2, 16'h1111, 16'h2222, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    go(3'd1, 16'h0800, 16'hFFFF, 1'b1, 1'b1);
    @(negedge clk); pins("R9 hidden addr phase", 8'h11, 8'h11, 0, 1, 1, 0, 0);
    @(negedge clk); pins("R9 hidden data phase", 8'h22, 8'h22, 0, 1, 1, 0, 1);
    to_idle();
  endtask

  task automatic t_ivis_int();
    narrow_mode = 1'b1; int_vis = 1'b1;
    go(3'd1, 16'h0900, 16'h3C5A, 1'b1, 1'b1);
    @(negedge clk); pins("R10 visible int addr", 8'h09, 8'h00, 0, 0, 1, 0, 0);
    @(negedge clk); pins("R10 visible int data", 8'h3C, 8'h5A, 1, 0, 1, 0, 1);
    to_idle();
  endtask

  task automatic t_debug_idle();
    narrow_mode = 1'b0; int_vis = 1'b1;
    go(3'd2, 16'h1111, 16'h2222, 1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    go(3'd4, 16'h5554, 16'h0000, 1'b1, 1'b0);
    @(negedge clk); pins("R11 debug addr strobe updated", 8'h55, 8'h54, 0, 1, 0, 0, 0);
    @(negedge clk); pins("R11 debug data held", 8'h22, 8'h22, 1, 1, 0, 0, 1);
    go(3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    @(negedge clk); pins("R12 idle addr held", 8'h55, 8'h54, 0, 1, 0, 1, 0);
    @(negedge clk); pins("R12 idle data e pulse", 8'h22, 8'h22, 1, 1, 0, 1, 1);
    int_vis = 1'b0;
    @(negedge clk); @(negedge clk);
    pins("R12 idle hidden e low", 8'h22, 8'h22, 0, 1, 0, 1, 1);
  endtask

  initial begin
    rst_n = 1'b0; narrow_mode = 1'b0; int_vis = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; porta_in = '0; portb_in = '0;
    to_idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_wide_write();
    t_wide_read();
    t_narrow_split_write();
    t_narrow_split_read();
    t_narrow_byte();
    t_narrow_reg();
    t_hidden();
    t_ivis_int();
    t_debug_idle();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

endmodule